// File: doc/BRIEF.md
# Command-Sequence Write Lock

This block sits beside the page-write controller of a parallel byte-wide EEPROM. It guards the array against stray writes. Each byte that the page-write front end captures reaches it as a one-cycle strobe with a 15-bit address and an 8-bit data value. The block checks each byte against two fixed address/data command sequences.

A three-byte arming sequence switches the array into its locked mode. Once the array is locked, that same sequence must open every write load. A six-byte release sequence switches the lock off. The bytes of a release load are never committed.

The page-write controller raises `load_end` when the byte-load window of a load has closed. One cycle later this block returns exactly one verdict for that load: commit or discard. The lock mode is held in a register that stands in for a non-volatile cell. The lock is off after reset, which is the as-delivered state.

The matcher is a state machine with these states:
- `ST_IDLE`: waiting for the first byte of a load.
- `ST_HEAD`: the first command byte has been seen.
- `ST_SECOND`: the second command byte has been seen.
- `ST_OPEN`: the arming sequence is complete.
- `ST_DIS1`, `ST_DIS2`, `ST_DIS3`: partway through the release sequence.
- `ST_OFF`: the release sequence is complete.

Its transitions are:
- advance on the expected byte;
- fall back to `ST_IDLE` on any other byte and set the stray flag;
- absorb further bytes in `ST_OPEN` and `ST_OFF`;
- return to `ST_IDLE` on `load_end`, which also clears the stray flag.

Top module: `wp_cmd_lock`

## Requirements
- R1: After reset, `prot_on`, `commit_go` and `commit_kill` are all 0.
- R2: A byte counts as a command byte only when both its address and its data match exactly. The command bytes are: address 0x5555 with data 0xAA, 0xA0, 0x80 or 0x20, and address 0x2AAA with data 0x55. Any other address or data, for example 0xAA at 0x5554, is a plain byte.
- R3: The arming sequence is 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0. A load that begins with it gives `commit_go` and sets `prot_on` to 1, whether or not the lock was already on.
- R4: While `prot_on` is 1, a load that begins with the arming sequence is committed, and `prot_on` stays 1.
- R5: While `prot_on` is 1, a load that does not begin with the arming sequence gives `commit_kill`. This includes an incomplete sequence and an empty load. `prot_on` stays 1.
- R6: The release sequence is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. A load that begins with it gives `commit_kill` and clears `prot_on`, in either mode.
- R7: While `prot_on` is 0, a load that begins with neither sequence gives `commit_go`, and `prot_on` stays 0.
- R8: A sequence counts only when it occupies the first bytes of a load. A mismatching byte returns the matcher to idle. After that, no later sequence in the same load changes the mode, and the verdict follows the current mode.
- R9: Each `load_end` pulse gives exactly one of `commit_go` or `commit_kill`, high for one cycle in the cycle after the pulse. `prot_on` takes its new value in that same cycle. Neither verdict is raised at any other time.
- R10: `load_end` returns the matcher to idle. A sequence split across two loads does not complete.
- R11: A strobe that arrives in the same cycle as `load_end` is ignored.
- R12: Bytes that follow a completed sequence within the same load do not alter the outcome of that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse marking a captured write byte |
| wr_addr | input | 15 | Address of the captured byte |
| wr_data | input | 8 | Data of the captured byte |
| load_end | input | 1 | Pulse: the byte-load window of the current load has closed |
| prot_on | output | 1 | Lock mode (1 = locked) |
| commit_go | output | 1 | Pulse: the load may be written to the array |
| commit_kill | output | 1 | Pulse: the load must be discarded |

## Verification
A byte strobed at one clock edge only changes matcher state. The verdict and any change of `prot_on` both appear one cycle after the edge that samples `load_end`. The bench drives every input on falling edges. It reads `commit_go`, `commit_kill` and `prot_on` on the falling edge that directly follows the `load_end` edge, exactly one register stage later, and it looks one cycle further to confirm that the verdict has dropped again. The sweep covers every load of one to four bytes drawn from the five command bytes and one plain byte, in both modes. Six-byte, split, stray-byte and same-cycle cases are run as directed loads.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

    typedef enum logic [2:0] {
        TK_PLAIN,
        TK_HEAD,
        TK_SECOND,
        TK_ARM,
        TK_ERASE,
        TK_RELEASE
    } tok_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SECOND,
        ST_OPEN,
        ST_DIS1,
        ST_DIS2,
        ST_DIS3,
        ST_OFF
    } mstate_t;

endpackage

// File: rtl/wp_byte_class.sv
module wp_byte_class
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR      = 15'h5555,
    parameter logic [ADDR_W-1:0] LO_ADDR      = 15'h2AAA,
    parameter logic [DATA_W-1:0] HEAD_DATA    = 8'hAA,
    parameter logic [DATA_W-1:0] SECOND_DATA  = 8'h55,
    parameter logic [DATA_W-1:0] ARM_DATA     = 8'hA0,
    parameter logic [DATA_W-1:0] ERASE_DATA   = 8'h80,
    parameter logic [DATA_W-1:0] RELEASE_DATA = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output tok_t              tok
);

    logic at_hi;
    logic at_lo;

    assign at_hi = (addr == HI_ADDR);
    assign at_lo = (addr == LO_ADDR);

    // R2: exact address and data match only
    always_comb begin
        tok = TK_PLAIN;
        if (at_hi && data == HEAD_DATA)         tok = TK_HEAD;
        else if (at_lo && data == SECOND_DATA)  tok = TK_SECOND;
        else if (at_hi && data == ARM_DATA)     tok = TK_ARM;
        else if (at_hi && data == ERASE_DATA)   tok = TK_ERASE;
        else if (at_hi && data == RELEASE_DATA) tok = TK_RELEASE;
    end

    always_comb begin
        assert_class_addr_R2: assert (tok == TK_PLAIN || at_hi || at_lo);
    end

endmodule

// File: rtl/wp_seq_match.sv
module wp_seq_match
    import wp_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stb,
    input  tok_t    tok,
    input  logic    load_end,
    output mstate_t state,
    output logic    stray
);

    mstate_t state_nx;
    logic    stray_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            stray <= 1'b0;
        end else begin
            state <= state_nx;
            stray <= stray_nx;
        end
    end

    always_comb begin
        state_nx = state;
        stray_nx = stray;
        if (load_end) begin
            // R10, R11: window closed, any same-cycle strobe dropped
            state_nx = ST_IDLE;
            stray_nx = 1'b0;
        end else if (stb) begin
            unique case (state)
                ST_IDLE: begin
                    if (tok == TK_HEAD) state_nx = ST_HEAD;
                    else                stray_nx = 1'b1;
                end
                ST_HEAD: begin
                    if (tok == TK_SECOND) state_nx = ST_SECOND;
                    else begin
                        state_nx = ST_IDLE;
                        stray_nx = 1'b1;
                    end
                end
                ST_SECOND: begin
                    if (tok == TK_ARM)        state_nx = ST_OPEN;
                    else if (tok == TK_ERASE) state_nx = ST_DIS1;
                    else begin
                        state_nx = ST_IDLE;
                        stray_nx = 1'b1;
                    end
                end
                ST_DIS1: begin
                    if (tok == TK_HEAD) state_nx = ST_DIS2;
                    else begin
                        state_nx = ST_IDLE;
                        stray_nx = 1'b1;
                    end
                end
                ST_DIS2: begin
                    if (tok == TK_SECOND) state_nx = ST_DIS3;
                    else begin
                        state_nx = ST_IDLE;
                        stray_nx = 1'b1;
                    end
                end
                ST_DIS3: begin
                    if (tok == TK_RELEASE) state_nx = ST_OFF;
                    else begin
                        state_nx = ST_IDLE;
                        stray_nx = 1'b1;
                    end
                end
                ST_OPEN: state_nx = ST_OPEN;   // R12: absorb data bytes
                ST_OFF:  state_nx = ST_OFF;    // R12
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |=> (state == ST_IDLE && !stray));

    assert_stray_on_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stray) |-> ($past(stb) && !$past(load_end)));

    assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !load_end) |=> state == ST_OPEN);

endmodule

// File: rtl/wp_mode_keep.sv
module wp_mode_keep
    import wp_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_end,
    input  mstate_t state,
    input  logic    stray,
    output logic    prot,
    output logic    go,
    output logic    kill
);

    logic prot_nx;
    logic allow;

    always_comb begin
        prot_nx = prot;
        allow   = !prot;
        if (!stray && state == ST_OFF) begin
            prot_nx = 1'b0;          // R6
            allow   = 1'b0;
        end else if (!stray && state == ST_OPEN) begin
            prot_nx = 1'b1;          // R3, R4
            allow   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= 1'b0;            // R1
            go   <= 1'b0;
            kill <= 1'b0;
        end else begin
            go   <= load_end && allow;
            kill <= load_end && !allow;
            if (load_end) prot <= prot_nx;
        end
    end

    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |=> (go ^ kill));

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_end |=> (!go && !kill));

    assert_mode_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot)) |-> $past(load_end));

    assert_lock_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot) |-> go);

    assert_release_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot) |-> kill);

endmodule

// File: rtl/wp_cmd_lock.sv
module wp_cmd_lock
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_end,
    output logic              prot_on,
    output logic              commit_go,
    output logic              commit_kill
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(15'h5555);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(15'h2AAA);

    tok_t    tok;
    mstate_t m_state;
    logic    m_stray;

    wp_byte_class #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HI_ADDR (HI_A),
        .LO_ADDR (LO_A)
    ) u_class (
        .addr (wr_addr),
        .data (wr_data),
        .tok  (tok)
    );

    wp_seq_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (wr_stb),
        .tok      (tok),
        .load_end (load_end),
        .state    (m_state),
        .stray    (m_stray)
    );

    wp_mode_keep u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_end (load_end),
        .state    (m_state),
        .stray    (m_stray),
        .prot     (prot_on),
        .go       (commit_go),
        .kill     (commit_kill)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!prot_on && !commit_go && !commit_kill));

endmodule

// File: tb/wp_cmd_lock_test.sv
module wp_cmd_lock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_end = 1'b0;
    logic        prot_on, commit_go, commit_kill;

    int total = 0;
    int bad = 0;
    bit exp_prot = 1'b0;
    int seq [8];

    always #2.5 clk = ~clk;

    wp_cmd_lock uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_end(load_end), .prot_on(prot_on),
        .commit_go(commit_go), .commit_kill(commit_kill)
    );

    // token codes: 0 AA@5555, 1 55@2AAA, 2 A0@5555, 3 80@5555, 4 20@5555,
    // 5 plain 5A@1234, 6 AA@5554 (near miss)
    function automatic logic [22:0] tok_bits(input int t);
        case (t)
            0: return {15'h5555, 8'hAA};
            1: return {15'h2AAA, 8'h55};
            2: return {15'h5555, 8'hA0};
            3: return {15'h5555, 8'h80};
            4: return {15'h5555, 8'h20};
            6: return {15'h5554, 8'hAA};
            default: return {15'h1234, 8'h5A};
        endcase
    endfunction

    task automatic check(input string tag, input logic got, input logic want, input string what);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, want);
        end
    endtask

    task automatic send_byte(input int t, input bit with_end);
        @(negedge clk);
        wr_stb = 1'b1;
        {wr_addr, wr_data} = tok_bits(t);
        load_end = with_end;
        @(negedge clk);
        wr_stb = 1'b0;
        load_end = 1'b0;
    endtask

    // run seq[0..n-1] as one load and check verdict, mode and pulse width
    task automatic do_load(input int n, input bit want_go, input bit want_prot, input string tag);
        for (int i = 0; i < n; i++) send_byte(seq[i], 1'b0);
        @(negedge clk);
        load_end = 1'b1;
        @(negedge clk);
        load_end = 1'b0;
        check(tag, commit_go, want_go, "commit_go");
        check(tag, commit_kill, !want_go, "commit_kill");
        check(tag, prot_on, want_prot, "prot_on");
        exp_prot = want_prot;
        @(negedge clk);
        total++;
        if (commit_go !== 1'b0 || commit_kill !== 1'b0) begin
            bad++;
            $display("FAIL R9 verdict width actual=%0b%0b expected=00", commit_go, commit_kill);
        end
    endtask

    task automatic load_arm_plain();
        seq[0] = 0; seq[1] = 1; seq[2] = 2; seq[3] = 5;
        do_load(4, 1'b1, 1'b1, "R3");
    endtask

    task automatic load_release();
        seq[0] = 0; seq[1] = 1; seq[2] = 3; seq[3] = 0; seq[4] = 1; seq[5] = 4;
        do_load(6, 1'b0, 1'b0, "R6");
    endtask

    task automatic set_mode(input bit want);
        if (exp_prot != want) begin
            if (want) load_arm_plain();
            else      load_release();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", prot_on, 1'b0, "prot_on");
        check("R1", commit_go, 1'b0, "commit_go");
        check("R1", commit_kill, 1'b0, "commit_kill");
        rst_n = 1'b1;
        @(negedge clk);

        // R7: plain load unlocked
        seq[0] = 5; seq[1] = 5;
        do_load(2, 1'b1, 1'b0, "R7");
        // R3: arm from unlocked
        load_arm_plain();
        // R5: empty load while locked
        do_load(0, 1'b0, 1'b1, "R5");
        // R2: near-miss address does not start the sequence
        seq[0] = 6; seq[1] = 1; seq[2] = 2; seq[3] = 5;
        do_load(4, 1'b0, 1'b1, "R2");
        // R6: release in locked mode, then R7 plain load
        load_release();
        seq[0] = 5;
        do_load(1, 1'b1, 1'b0, "R7");
        // R6: release while already unlocked still discards
        load_release();
        // R12: extra bytes after release
        seq[0] = 0; seq[1] = 1; seq[2] = 3; seq[3] = 0; seq[4] = 1; seq[5] = 4; seq[6] = 5; seq[7] = 2;
        do_load(8, 1'b0, 1'b0, "R12");
        // R8: stray byte ahead of release, locked mode -> kill, stays locked
        load_arm_plain();
        seq[0] = 5; seq[1] = 0; seq[2] = 1; seq[3] = 3; seq[4] = 0; seq[5] = 1; seq[6] = 4;
        do_load(7, 1'b0, 1'b1, "R8");
        // R8: broken release then arm within same load -> still kill
        seq[0] = 0; seq[1] = 1; seq[2] = 3; seq[3] = 5; seq[4] = 0; seq[5] = 1; seq[6] = 2;
        do_load(7, 1'b0, 1'b1, "R8");
        // R10: arming split across two loads
        load_release();
        seq[0] = 0; seq[1] = 1;
        do_load(2, 1'b1, 1'b0, "R10");
        seq[0] = 2; seq[1] = 5;
        do_load(2, 1'b1, 1'b0, "R10");
        // R11: third arming byte strobed together with load_end
        send_byte(0, 1'b0);
        send_byte(1, 1'b0);
        send_byte(2, 1'b1);
        check("R11", commit_go, 1'b1, "commit_go");
        check("R11", prot_on, 1'b0, "prot_on");
        @(negedge clk);
        seq[0] = 5;
        do_load(1, 1'b1, 1'b0, "R11");

        // sweep: every load of 1..4 bytes from tokens 0..5, both modes
        for (int m = 0; m < 2; m++) begin
            for (int n = 1; n <= 4; n++) begin
                int pw;
                pw = 1;
                for (int k = 0; k < n; k++) pw = pw * 6;
                for (int code = 0; code < pw; code++) begin
                    int c;
                    bit arm;
                    set_mode(m[0]);
                    c = code;
                    for (int k = 0; k < n; k++) begin
                        seq[k] = c % 6;
                        c = c / 6;
                    end
                    arm = (n >= 3) && seq[0] == 0 && seq[1] == 1 && seq[2] == 2;
                    if (arm)       do_load(n, 1'b1, 1'b1, m ? "R4" : "R3");
                    else if (m[0]) do_load(n, 1'b0, 1'b1, "R5");
                    else           do_load(n, 1'b1, 1'b0, "R7");
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule